// File: doc/BRIEF.md
# Switch Bounce Duration Meter

The block measures how long a mechanical switch takes to settle its first bounce after it closes. A raw, asynchronous switch level enters through a synchroniser. Once the block is armed, it waits for the synchronised level to be low and then for it to rise. From that rising edge it counts clock cycles through the following low interval, until the level rises again. That cycle count is the length of the first make-break-make interval. With a 100 MHz clock, one count is 10 ns.

If the switch closes cleanly and stays high for longer than a timeout window, the block reports that no bounce was seen instead of waiting forever. The default window is 100000 cycles, which is 1 ms at 100 MHz. If the break lasts so long that the interval passes the window, the count saturates at the window length. A finished result stays on the outputs until the block is armed again. No switch activity changes it in the meantime.

Top module: `bounce_meter`

## Requirements
- R1: After reset, `done_o`, `no_bounce_o` and `span_o` are all 0.
- R2: After arming, suppose the switch is low, then high for H cycles, then low for L cycles, then high again. If H+L ≤ TIMEOUT_CYC, the block ends with `done_o`=1, `no_bounce_o`=0 and `span_o`=H+L.
- R3: Suppose H ≤ TIMEOUT_CYC and H+L > TIMEOUT_CYC, or the low interval never ends. The block ends with `done_o`=1, `no_bounce_o`=0 and `span_o`=TIMEOUT_CYC. `span_o` never exceeds TIMEOUT_CYC.
- R4: If the first high interval lasts more than TIMEOUT_CYC cycles, the block ends with `done_o`=1, `no_bounce_o`=1 and `span_o`=0. Whenever `no_bounce_o` is 1, `done_o` is 1 and `span_o` is 0.
- R5: A cycle with `arm_i`=1 clears `done_o`, `no_bounce_o` and `span_o` to 0 from the next cycle on, and restarts the measurement.
- R6: After arming, a rise is counted only after the synchronised input has been seen low. If the block is armed while the switch is held high and the switch stays high, `done_o` stays 0.
- R7: While `done_o`=1 and `arm_i`=0, `done_o`, `no_bounce_o` and `span_o` hold their values through any switch activity.
- R8: Before the first arm after reset, switch activity leaves `done_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock; one period is one count |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Clears the result and starts a new measurement |
| sw_i | input | 1 | Raw asynchronous switch level |
| span_o | output | CNT_W | Cycles from the first rise to the next rise, saturated at TIMEOUT_CYC |
| done_o | output | 1 | A result is valid |
| no_bounce_o | output | 1 | The first high interval outlasted the timeout window |

## Verification
The hardest cases to reach are the two edges of the timeout window. One is the first high interval ending exactly at the window, or one cycle after it. The other is the break running past the window, which must saturate the count instead of wrapping it. The bench uses a small window of 40 cycles and sweeps every high length from 1 to two past the window against a range of low lengths. It drives the switch one clock at a time, so that each expected count follows from simple arithmetic. It also arms the block with the switch still held high, so that the wait-for-low path is exercised on every pass.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_LOW,
    ST_WAIT_RISE,
    ST_MAKE,
    ST_BREAK,
    ST_DONE
  } bm_state_e;
endpackage

// File: rtl/bm_sync.sv
module bm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q[0] <= 1'b0;
    else         q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[i] <= 1'b0;
      else         q[i] <= q[i-1];
    end
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/bm_span_counter.sv
module bm_span_counter #(
  parameter int LIMIT = 100000,
  parameter int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_limit_o
);
  localparam logic [CNT_W-1:0] LimitV = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= CNT_W'(1);
    else if (inc_i && cnt_q != LimitV) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o      = cnt_q;
  assign at_limit_o = (cnt_q == LimitV);

  // R3
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == LimitV && !load_i |=> cnt_q == LimitV);
endmodule

// File: rtl/bm_ctrl.sv
module bm_ctrl
  import bm_pkg::*;
#(
  parameter int LIMIT = 100000,
  parameter int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             s_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             at_limit_i,
  output logic             load_o,
  output logic             inc_o,
  output logic [CNT_W-1:0] span_o,
  output logic             done_o,
  output logic             no_bounce_o
);
  bm_state_e        st_q, st_d;
  logic [CNT_W-1:0] span_q, fin_span;
  logic             done_q, nb_q, fin, fin_nb;

  always_comb begin
    st_d     = st_q;
    load_o   = 1'b0;
    inc_o    = 1'b0;
    fin      = 1'b0;
    fin_nb   = 1'b0;
    fin_span = '0;
    unique case (st_q)
      ST_WAIT_LOW:  if (!s_i) st_d = ST_WAIT_RISE;
      ST_WAIT_RISE: if (s_i) begin
        st_d   = ST_MAKE;
        load_o = 1'b1;
      end
      ST_MAKE: begin
        if (!s_i) begin
          st_d  = ST_BREAK;
          inc_o = 1'b1;
        end else if (at_limit_i) begin
          st_d   = ST_DONE;
          fin    = 1'b1;
          fin_nb = 1'b1;
        end else begin
          inc_o = 1'b1;
        end
      end
      ST_BREAK: begin
        if (s_i || at_limit_i) begin
          // remake, or break outlasted the window: counter is already saturated
          st_d     = ST_DONE;
          fin      = 1'b1;
          fin_span = cnt_i;
        end else begin
          inc_o = 1'b1;
        end
      end
      default: ;
    endcase
    if (arm_i) begin
      st_d   = ST_WAIT_LOW;
      load_o = 1'b0;
      inc_o  = 1'b0;
      fin    = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      nb_q   <= 1'b0;
      span_q <= '0;
    end else begin
      st_q <= st_d;
      if (arm_i) begin
        done_q <= 1'b0;
        nb_q   <= 1'b0;
        span_q <= '0;
      end else if (fin) begin
        done_q <= 1'b1;
        nb_q   <= fin_nb;
        span_q <= fin_span;
      end
    end
  end

  assign span_o      = span_q;
  assign done_o      = done_q;
  assign no_bounce_o = nb_q;

  // R7
  hold_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !arm_i |=> done_q && $stable(span_q) && $stable(nb_q));
  // R4
  nb_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nb_q |-> done_q && span_q == '0);
  // R5
  arm_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> !done_q && !nb_q && span_q == '0);
  // R3
  span_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    span_q <= CNT_W'(LIMIT));
  // R6
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(st_q) == ST_MAKE || $past(st_q) == ST_BREAK);
endmodule

// File: rtl/bounce_meter.sv
module bounce_meter #(
  parameter int TIMEOUT_CYC = 100000,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             sw_i,
  output logic [CNT_W-1:0] span_o,
  output logic             done_o,
  output logic             no_bounce_o
);
  logic             sw_s, load, inc, at_limit;
  logic [CNT_W-1:0] cnt;

  bm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(sw_i), .q_o(sw_s)
  );

  bm_span_counter #(.LIMIT(TIMEOUT_CYC), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .inc_i(inc), .cnt_o(cnt), .at_limit_o(at_limit)
  );

  bm_ctrl #(.LIMIT(TIMEOUT_CYC), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .arm_i, .s_i(sw_s), .cnt_i(cnt), .at_limit_i(at_limit),
    .load_o(load), .inc_o(inc), .span_o, .done_o, .no_bounce_o
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !done_o && !no_bounce_o);
endmodule

// File: tb/bounce_meter_tb_top.sv
module bounce_meter_tb_top;
  localparam int T = 40;
  localparam int W = $clog2(T + 1);

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, sw = 1'b0;
  logic [W-1:0] span;
  logic done, nb;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bounce_meter #(.TIMEOUT_CYC(T)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .sw_i(sw),
    .span_o(span), .done_o(done), .no_bounce_o(nb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_arm();
    arm = 1'b1;
    step(1);
    arm = 1'b0;
    // R5: cleared right after the arm cycle
    check(!done && !nb && span == '0, "R5 arm clears", int'(done) + int'(nb) + int'(span), 0);
  endtask

  task automatic wait_done(input int cap);
    for (int i = 0; i < cap; i++) begin
      if (done) break;
      step(1);
    end
  endtask

  task automatic run(input int h, input int l);
    int exp_span, exp_nb, snap;
    pulse_arm();
    sw = 1'b0; step(4);
    sw = 1'b1; step(h);
    sw = 1'b0; step(l);
    sw = 1'b1; wait_done(3 * T);
    exp_nb   = (h > T) ? 1 : 0;
    exp_span = (h > T) ? 0 : ((h + l > T) ? T : h + l);
    if (h > T)
      check(done && nb == 1'b1 && int'(span) == 0, "R4 no bounce", int'(span) + 100 * int'(nb), 100);
    else if (h + l > T)
      check(done && !nb && int'(span) == exp_span, "R3 saturate", int'(span), exp_span);
    else
      check(done && nb == 1'(exp_nb) && int'(span) == exp_span, "R2 span", int'(span), exp_span);
    snap = int'(span);
    sw = 1'b0; step(3);
    sw = 1'b1; step(3);
    sw = 1'b0; step(2);
    sw = 1'b1; step(1);
    // R7: result held through later activity
    check(done && int'(nb) == exp_nb && int'(span) == snap, "R7 hold", int'(span), snap);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1
    check(!done, "R1 done", int'(done), 0);
    check(!nb, "R1 no_bounce", int'(nb), 0);
    check(span == '0, "R1 span", int'(span), 0);
    // R8: no arm yet, activity ignored
    sw = 1'b1; step(5); sw = 1'b0; step(3); sw = 1'b1; step(4); sw = 1'b0; step(T + 10);
    check(!done && span == '0, "R8 idle", int'(done), 0);
    // R6: armed while held high, never drops
    sw = 1'b1; step(4);
    pulse_arm();
    step(3 * T);
    check(!done, "R6 wait for low", int'(done), 0);
    sw = 1'b0; step(4);
    sw = 1'b1; step(5);
    sw = 1'b0; step(2);
    sw = 1'b1; wait_done(3 * T);
    check(done && int'(span) == 7, "R6 span after low", int'(span), 7);
    // R3: break never ends
    pulse_arm();
    sw = 1'b0; step(4);
    sw = 1'b1; step(3);
    sw = 1'b0; wait_done(3 * T);
    check(done && !nb && int'(span) == T, "R3 endless break", int'(span), T);
    // sweep, sw left high between runs so every arm passes through wait-for-low
    for (int h = 1; h <= T + 2; h++)
      for (int l = 1; l <= 10; l++)
        run(h, (l == 10) ? T : l);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule